// File: doc/BRIEF.md
# Ping-Pong Frame Buffer Fetch Engine

This block keeps a display pixel FIFO topped up from system memory, so that a raster panel can be refreshed continuously without processor involvement. Software describes one or two frame buffers. Each buffer is a start address and an inclusive last (ceiling) address. The engine walks those addresses one word at a time over a simple read request/response port. It registers each returned word into the FIFO.

In two-buffer mode the engine alternates between the buffers. This lets software redraw one buffer while the other is being scanned out. In one-buffer mode it rescans buffer 0 and ignores buffer 1. A one-cycle event marks the completion of each buffer, with a separate pulse for each of the two buffers. A further pulse reports that the display side tried to pop an empty FIFO, which means memory could not keep pace with the pixel rate.

The engine checks the FIFO occupancy reported to it before each request. This keeps the FIFO from being overrun by data that is already on its way.

Top module: `frame_fetch_dma`

## Requirements
- R1: While `rst_n` is low, `rd_req`, `fifo_wr`, `eof0`, `eof1` and `underrun` are all 0.
- R2: No read is requested before `enable` is first sampled high. The first read after enabling targets `fb0_base`.
- R3: A read is requested only when `fifo_level` plus accepted-but-unwritten reads plus one does not exceed `DEPTH`. The FIFO therefore never overflows.
- R4: A read is accepted in a cycle where `rd_req` and `rd_gnt` are both 1. Within a buffer, each accepted read advances `rd_addr` by exactly one word. While a request is not accepted, `rd_addr` holds.
- R5: `eof0` pulses for one cycle, in the cycle after the read of `fb0_ceil` from buffer 0 is accepted. `eof1` does the same for `fb1_ceil` from buffer 1.
- R6: When `dual_mode` = 1, the read after buffer 0's ceiling targets `fb1_base`, and the read after buffer 1's ceiling targets `fb0_base`.
- R7: When `dual_mode` = 0, the read after `fb0_ceil` targets `fb0_base` again. `fb1_base` and `fb1_ceil` have no effect, and `eof1` stays 0.
- R8: Every cycle with `rd_valid` = 1 produces `fifo_wr` = 1 in the next cycle, with `fifo_wdata` equal to that `rd_data`. `fifo_wr` is 0 otherwise.
- R9: `underrun` pulses in the cycle after one where `disp_pop` = 1 while `fifo_level` = 0. At all other times it is 0.
- R10: From the cycle after `enable` is sampled low, `rd_req` stays 0. Outstanding reads still drain into the FIFO. Re-enabling resumes at `fb0_base` in buffer 0 once nothing is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run control for fetching |
| dual_mode | input | 1 | 1 = alternate between two buffers, 0 = buffer 0 only |
| fb0_base | input | AW | First word address of buffer 0 |
| fb0_ceil | input | AW | Last word address of buffer 0 |
| fb1_base | input | AW | First word address of buffer 1 |
| fb1_ceil | input | AW | Last word address of buffer 1 |
| fifo_level | input | LW | Current pixel FIFO occupancy |
| disp_pop | input | 1 | Display side reads a FIFO entry this cycle |
| rd_req | output | 1 | Read request valid |
| rd_addr | output | AW | Word address of the read request |
| rd_gnt | input | 1 | Memory accepts the request this cycle |
| rd_valid | input | 1 | Read data returning this cycle |
| rd_data | input | DW | Returned read data |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | DW | FIFO write data |
| eof0 | output | 1 | Buffer 0 completed (one-cycle pulse) |
| eof1 | output | 1 | Buffer 1 completed (one-cycle pulse) |
| underrun | output | 1 | Pop on empty FIFO detected (one-cycle pulse) |

## Verification
The bench builds the block with `DEPTH` = 8, so a slow consumer fills the FIFO within a few cycles and the credit limit of R3 is exercised constantly rather than rarely. A memory return latency of three cycles keeps several reads outstanding against that small depth. Buffers of three to six words, plus a phase with one-word buffers where base equals ceiling, produce hundreds of buffer switches in both modes. Address and data widths of 16 bits keep the expected values readable without narrowing any behaviour.

// File: rtl/fbd_pkg.sv
`timescale 1ns/1ps
package fbd_pkg;
    // Identifies which of the two frame buffers is being scanned.
    typedef enum logic {
        BUF_A = 1'b0,
        BUF_B = 1'b1
    } buf_id_e;
endpackage

// File: rtl/fbd_addr_gen.sv
`timescale 1ns/1ps
// Address walker: steps through the active buffer and switches at its ceiling.
module fbd_addr_gen
    import fbd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          accept,
    input  logic          dual_mode,
    input  logic [AW-1:0] base0,
    input  logic [AW-1:0] ceil0,
    input  logic [AW-1:0] base1,
    input  logic [AW-1:0] ceil1,
    output logic [AW-1:0] addr,
    output logic          eof0,
    output logic          eof1
);
    typedef struct packed {
        logic [AW-1:0] addr;
        buf_id_e       sel;
        logic          eof0;
        logic          eof1;
    } walk_t;

    walk_t st_d, st_q;
    logic [AW-1:0] cur_ceil;

    always_comb begin
        st_d      = st_q;
        st_d.eof0 = 1'b0;
        st_d.eof1 = 1'b0;
        cur_ceil  = (st_q.sel == BUF_A) ? ceil0 : ceil1;
        if (!run) begin
            // Idle: park on the start of buffer 0.
            st_d.addr = base0;
            st_d.sel  = BUF_A;
        end else if (accept) begin
            if (st_q.addr == cur_ceil) begin
                if (st_q.sel == BUF_A) st_d.eof0 = 1'b1;
                else                   st_d.eof1 = 1'b1;
                if (dual_mode && st_q.sel == BUF_A) begin
                    st_d.sel  = BUF_B;
                    st_d.addr = base1;
                end else begin
                    st_d.sel  = BUF_A;
                    st_d.addr = base0;
                end
            end else begin
                st_d.addr = st_q.addr + AW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{addr: '0, sel: BUF_A, eof0: 1'b0, eof1: 1'b0};
        else        st_q <= st_d;
    end

    assign addr = st_q.addr;
    assign eof0 = st_q.eof0;
    assign eof1 = st_q.eof1;
endmodule

// File: rtl/fbd_credit.sv
`timescale 1ns/1ps
// Tracks reads in flight and grants room only when the FIFO can absorb one more.
module fbd_credit #(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          ret_valid,
    input  logic          wr_pending,
    input  logic [LW-1:0] level,
    output logic          room,
    output logic          drained
);
    localparam int SW = LW + 2;
    localparam logic [SW-1:0] LIMIT = SW'(DEPTH);
    localparam logic [SW-1:0] ONE   = SW'(1);

    typedef struct packed {
        logic [LW-1:0] outs;
    } credit_t;

    credit_t st_d, st_q;
    logic [SW-1:0] need;

    always_comb begin
        st_d      = st_q;
        st_d.outs = st_q.outs + LW'(accept) - LW'(ret_valid);
        need      = SW'(level) + SW'(st_q.outs) + SW'(wr_pending) + ONE;
        room      = (need <= LIMIT);
        drained   = (st_q.outs == '0) && !wr_pending;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{outs: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fbd_wr_stage.sv
`timescale 1ns/1ps
// Registers returned words into the FIFO and flags pops on an empty FIFO.
module fbd_wr_stage #(
    parameter int DW = 16,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ret_valid,
    input  logic [DW-1:0] ret_data,
    input  logic          disp_pop,
    input  logic [LW-1:0] level,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_wdata,
    output logic          underrun
);
    typedef struct packed {
        logic          wr;
        logic [DW-1:0] data;
        logic          uf;
    } wr_t;

    wr_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wr   = ret_valid;
        st_d.uf   = disp_pop && (level == '0);
        if (ret_valid) st_d.data = ret_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{wr: 1'b0, data: '0, uf: 1'b0};
        else        st_q <= st_d;
    end

    assign fifo_wr    = st_q.wr;
    assign fifo_wdata = st_q.data;
    assign underrun   = st_q.uf;
endmodule

// File: rtl/frame_fetch_dma.sv
`timescale 1ns/1ps
module frame_fetch_dma #(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          dual_mode,
    input  logic [AW-1:0] fb0_base,
    input  logic [AW-1:0] fb0_ceil,
    input  logic [AW-1:0] fb1_base,
    input  logic [AW-1:0] fb1_ceil,
    input  logic [LW-1:0] fifo_level,
    input  logic          disp_pop,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_gnt,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_wdata,
    output logic          eof0,
    output logic          eof1,
    output logic          underrun
);
    typedef struct packed {
        logic run;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic room, drained, accept;

    // Start only from a drained state so a restart never mixes with old returns.
    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.run = enable && (ctl_q.run || drained);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{run: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign rd_req = ctl_q.run && room;
    assign accept = rd_req && rd_gnt;

    fbd_addr_gen #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctl_q.run),
        .accept    (accept),
        .dual_mode (dual_mode),
        .base0     (fb0_base),
        .ceil0     (fb0_ceil),
        .base1     (fb1_base),
        .ceil1     (fb1_ceil),
        .addr      (rd_addr),
        .eof0      (eof0),
        .eof1      (eof1)
    );

    fbd_credit #(.DEPTH(DEPTH), .LW(LW)) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .ret_valid  (rd_valid),
        .wr_pending (fifo_wr),
        .level      (fifo_level),
        .room       (room),
        .drained    (drained)
    );

    fbd_wr_stage #(.DW(DW), .LW(LW)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ret_valid  (rd_valid),
        .ret_data   (rd_data),
        .disp_pop   (disp_pop),
        .level      (fifo_level),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata),
        .underrun   (underrun)
    );
endmodule

// File: rtl/fbd_checker.sv
`timescale 1ns/1ps
module fbd_checker #(
    parameter int AW    = 16,
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          dual_mode,
    input logic [LW-1:0] fifo_level,
    input logic          disp_pop,
    input logic          rd_req,
    input logic          rd_gnt,
    input logic [AW-1:0] rd_addr,
    input logic          rd_valid,
    input logic          fifo_wr,
    input logic          eof0,
    input logic          eof1,
    input logic          underrun
);
    localparam int CW = LW + 2;
    logic [CW-1:0] inflight_q;

    // Independent count of reads granted but not yet written into the FIFO.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_q + CW'(rd_req && rd_gnt) - CW'(fifo_wr);
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!rd_req && !fifo_wr && !eof0 && !eof1 && !underrun));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(fifo_level) + inflight_q + CW'(rd_req && rd_gnt)) <= CW'(DEPTH));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_gnt && enable) |=> $stable(rd_addr));

    assert_eof_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(eof0 && eof1));

    assert_single_no_eof1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dual_mode) |-> !eof1);

    assert_wr_follows_ret_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> fifo_wr);

    assert_no_spurious_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !fifo_wr);

    assert_underrun_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_pop && fifo_level == '0) |=> underrun);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !$past(enable)) |-> !rd_req);
endmodule

bind frame_fetch_dma fbd_checker #(.AW(AW), .DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .dual_mode  (dual_mode),
    .fifo_level (fifo_level),
    .disp_pop   (disp_pop),
    .rd_req     (rd_req),
    .rd_gnt     (rd_gnt),
    .rd_addr    (rd_addr),
    .rd_valid   (rd_valid),
    .fifo_wr    (fifo_wr),
    .eof0       (eof0),
    .eof1       (eof1),
    .underrun   (underrun)
);

// File: tb/frame_fetch_dma_tb.sv
`timescale 1ns/1ps
module frame_fetch_dma_tb;
    localparam int AW    = 16;
    localparam int DW    = 16;
    localparam int DEPTH = 8;
    localparam int LW    = $clog2(DEPTH + 1);
    localparam int LAT   = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enable, dual_mode, disp_pop, rd_gnt, rd_valid;
    logic [AW-1:0] fb0_base, fb0_ceil, fb1_base, fb1_ceil;
    logic [LW-1:0] fifo_level;
    logic [DW-1:0] rd_data;
    logic          rd_req, fifo_wr, eof0, eof1, underrun;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] fifo_wdata;

    always #4 clk = ~clk;

    frame_fetch_dma #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .dual_mode(dual_mode),
        .fb0_base(fb0_base), .fb0_ceil(fb0_ceil), .fb1_base(fb1_base), .fb1_ceil(fb1_ceil),
        .fifo_level(fifo_level), .disp_pop(disp_pop), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_gnt(rd_gnt), .rd_valid(rd_valid), .rd_data(rd_data), .fifo_wr(fifo_wr),
        .fifo_wdata(fifo_wdata), .eof0(eof0), .eof1(eof1), .underrun(underrun)
    );

    int checks = 0, errs = 0;
    bit done = 1'b0;
    bit            pv [LAT];
    logic [AW-1:0] pa [LAT];
    int level_m = 0, outst_m = 0;
    bit exp_wr = 0, exp_e0 = 0, exp_e1 = 0, exp_uf = 0;
    logic [DW-1:0] exp_wd = '0;
    logic [AW-1:0] exp_addr;
    bit exp_sel = 0;
    string addr_tag = "R2";
    int pop_pct = 50, gnt_pct = 80;
    int eof0_seen = 0, eof1_seen = 0, uf_seen = 0;
    bit was_enabled = 0;

    function automatic logic [DW-1:0] data_of(input logic [AW-1:0] a);
        return DW'(a * 16'h9E37) ^ 16'h5A5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        bit acc, e0n, e1n;
        e0n = 0; e1n = 0;
        @(negedge clk);
        // Registered outputs produced by the last edge.
        chk(fifo_wr == exp_wr, "R8", fifo_wr, exp_wr);
        if (exp_wr) chk(fifo_wdata == exp_wd, "R8", fifo_wdata, exp_wd);
        chk(eof0 == exp_e0, "R5", eof0, exp_e0);
        chk(eof1 == exp_e1, dual_mode ? "R5" : "R7", eof1, exp_e1);
        chk(underrun == exp_uf, "R9", underrun, exp_uf);
        if (eof0) eof0_seen++;
        if (eof1) eof1_seen++;
        if (underrun) uf_seen++;
        // Drive this cycle's inputs.
        fifo_level = LW'(level_m);
        disp_pop   = ($urandom_range(99) < pop_pct);
        rd_valid   = pv[0];
        rd_data    = pv[0] ? data_of(pa[0]) : DW'($urandom);
        rd_gnt     = ($urandom_range(99) < gnt_pct);
        #1;
        acc = rd_req && rd_gnt;
        if (!enable) chk(!rd_req, was_enabled ? "R10" : "R2", rd_req, 0);
        chk((level_m + outst_m + int'(exp_wr) + int'(acc)) <= DEPTH, "R3",
            level_m + outst_m + int'(exp_wr) + int'(acc), DEPTH);
        if (acc) begin
            chk(rd_addr == exp_addr, addr_tag, rd_addr, exp_addr);
            addr_tag = "R4";
            if (exp_addr == (exp_sel ? fb1_ceil : fb0_ceil)) begin
                if (exp_sel) e1n = 1; else e0n = 1;
                if (dual_mode && !exp_sel) begin
                    exp_sel = 1; exp_addr = fb1_base; addr_tag = "R6";
                end else begin
                    exp_sel = 0; exp_addr = fb0_base; addr_tag = dual_mode ? "R6" : "R7";
                end
            end else begin
                exp_addr = exp_addr + AW'(1);
            end
            outst_m++;
        end
        if (!enable) begin
            exp_addr = fb0_base; exp_sel = 0; addr_tag = was_enabled ? "R10" : "R2";
        end
        if (rd_valid) outst_m--;
        exp_wr = rd_valid;
        exp_wd = rd_data;
        exp_uf = disp_pop && (level_m == 0);
        level_m = level_m + int'(fifo_wr) - int'(disp_pop && level_m > 0);
        for (int i = 0; i < LAT - 1; i++) begin
            pv[i] = pv[i+1];
            pa[i] = pa[i+1];
        end
        pv[LAT-1] = acc;
        pa[LAT-1] = rd_addr;
        exp_e0 = e0n;
        exp_e1 = e1n;
    endtask

    task automatic run(input int n, input int pop, input int gnt);
        pop_pct = pop;
        gnt_pct = gnt;
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic pause_and_config(input bit dual, input logic [AW-1:0] b0, input logic [AW-1:0] c0,
                                    input logic [AW-1:0] b1, input logic [AW-1:0] c1);
        enable = 0;
        run(20, 60, 80);
        dual_mode = dual;
        fb0_base = b0; fb0_ceil = c0; fb1_base = b1; fb1_ceil = c1;
        run(2, 60, 80);
        enable = 1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < LAT; i++) begin pv[i] = 0; pa[i] = '0; end
        enable = 0; dual_mode = 1; disp_pop = 0; rd_gnt = 0; rd_valid = 0; rd_data = '0;
        fifo_level = '0;
        fb0_base = 16'h0100; fb0_ceil = 16'h0105; fb1_base = 16'h0200; fb1_ceil = 16'h0202;
        exp_addr = fb0_base;
        rst_n = 1;
        #1 rst_n = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            // R1: quiet outputs in reset
            chk(!rd_req && !fifo_wr && !eof0 && !eof1 && !underrun, "R1",
                {rd_req, fifo_wr, eof0, eof1, underrun}, 0);
        end
        rst_n = 1;
        // R2: held off until enabled
        run(6, 0, 100);
        enable = 1; was_enabled = 1;
        // Dual mode, balanced traffic (R4, R5, R6, R8)
        run(600, 70, 80);
        // Slow consumer: FIFO fills, credit limit (R3)
        run(400, 5, 100);
        // Single mode with buffer 1 pointing elsewhere (R7, R10 restart)
        pause_and_config(0, 16'h0300, 16'h0303, 16'h0777, 16'h0700);
        run(400, 60, 90);
        // Starved memory: underruns (R9)
        run(300, 90, 5);
        // One-word buffers in dual mode (R5, R6)
        pause_and_config(1, 16'h0400, 16'h0400, 16'h0500, 16'h0500);
        run(300, 50, 70);
        // Disable mid-frame, then restart (R10)
        pause_and_config(1, 16'h0100, 16'h0105, 16'h0200, 16'h0202);
        run(200, 70, 80);
        chk(eof0_seen > 0, "R5", eof0_seen, 1);
        chk(eof1_seen > 0, "R6", eof1_seen, 1);
        chk(uf_seen > 0, "R9", uf_seen, 1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end
endmodule